// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block is the core of an eight-line interrupt controller. It keeps a request register, an in-service register and a stored copy of the input levels. Each cycle it chooses the most urgent unmasked request, starting the search at a base line that can be rotated. It raises its interrupt output only when that request outranks every line now in service. An acknowledge strobe moves the chosen request into service. Commands carry a 3-bit code and a 3-bit level. They end service for a line, or for the most urgent line in service, and they move the priority base.

Each input line is either edge or level sensitive. A constant parameter decides which lines may be level sensitive at all. When the controller is a master and fully nested operation is selected, the cascade line is left out of the in-service comparison, so a second request on that line can get through. In automatic end-of-interrupt mode an acknowledge does not set the in-service bit. If rotation on automatic end-of-interrupt is enabled, the acknowledge also moves the base.

Top module: `rot_prio_resolver`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `intReq` and `intLevel` are 0, all request and in-service bits are clear, the base is 0 and rotation on automatic end-of-interrupt is off.
- R2: A line that is edge sensitive sets its request bit only when its input is 1 and its previously sampled input was 0. The bit then stays set after the input falls, until an acknowledge clears it. A line is edge sensitive when `levelSel` is 0 for it, or when its bit of the constant `LEVEL_OK` is 0.
- R3: A line that is level sensitive (`levelSel` and `LEVEL_OK` both 1 for it) has its request bit equal to the input sampled at the last clock edge. An acknowledge does not clear that bit. The default value of `LEVEL_OK` is 8'hF8, so lines 3 to 7 may be level sensitive.
- R4: The priority search tests line (n + base) mod 8 for n = 0 up to 7. The first line found wins, and a smaller n is more urgent. `intLevel` carries the line number of the winner.
- R5: The candidate set is the request bits AND NOT `maskBits`. `intReq` is 1 only when the winner's n is strictly smaller than the n of the most urgent in-service line. An empty set counts as n = 8.
- R6: With `IS_MASTER` = 1 and `fullyNested` = 1, the in-service bit of line `NEST_LINE` (default 2) is left out of the comparison in R5.
- R7: `ackStrobe` while a request would be raised clears that line's request bit if the line is edge sensitive. It also sets that line's in-service bit, unless `autoEoi` is 1. If `autoEoi` is 1 and rotation is enabled, the base becomes line + 1 mod 8.
- R8: Command code 1 clears the most urgent in-service bit. Code 5 does the same and also sets the base to that line + 1 mod 8. When nothing is in service, neither code has any effect.
- R9: Command code 3 clears the in-service bit of `cmdLevel`. Code 7 does the same and also sets the base to `cmdLevel` + 1 mod 8.
- R10: Command code 6 sets the base to `cmdLevel` + 1 mod 8 and clears nothing. Code 2 changes nothing. A command's base change takes precedence over one from an acknowledge in the same cycle. An in-service clear takes precedence over a set of the same bit in the same cycle.
- R11: Command code 4 enables rotation on automatic end-of-interrupt and code 0 disables it. The enable is the code's bit 2.
- R12: `intReq` and `intLevel` are registered. One clock edge after any input pattern, they show the resolution of the updated registers together with the `maskBits` sampled at that edge. `intLevel` is 0 when `intReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqLines | input | 8 | Interrupt request inputs |
| levelSel | input | 8 | Per-line level sensitivity select (1 = level) |
| maskBits | input | 8 | Per-line mask (1 = masked) |
| fullyNested | input | 1 | Leave the cascade line out of the in-service comparison |
| autoEoi | input | 1 | Acknowledge does not set in-service |
| ackStrobe | input | 1 | Acknowledge the current winner |
| cmdStrobe | input | 1 | Apply the command on cmdCode and cmdLevel |
| cmdCode | input | 3 | Command code |
| cmdLevel | input | 3 | Line argument of the command |
| intReq | output | 1 | Registered interrupt request |
| intLevel | output | 3 | Registered winning line |

## Verification
The hardest state to reach is one where the in-service register is non-empty and the base is rotated. Command precedence, the strictly-greater test and the cascade-line exclusion only show up there. The directed part of the stimulus builds it step by step. It raises edges on several lines, acknowledges them into service, and then rotates the base with codes 5, 7 and 6. It also takes the cascade line into service twice while fully nested operation is on. A long pseudo-random phase follows. It mixes acknowledges and commands in the same cycle, and it toggles the edge or level choice on lines while their inputs are high.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);

  typedef enum logic [2:0] {
    CMD_ROT_OFF   = 3'd0,
    CMD_EOI_TOP   = 3'd1,
    CMD_NOP       = 3'd2,
    CMD_EOI_AT    = 3'd3,
    CMD_ROT_ON    = 3'd4,
    CMD_EOI_TOP_R = 3'd5,
    CMD_SET_BASE  = 3'd6,
    CMD_EOI_AT_R  = 3'd7
  } cmd_e;

  typedef struct packed {
    logic             ackGo;
    logic [IDX_W-1:0] ackLine;
    logic             setIsr;
    logic [LINES-1:0] isrClr;
    logic             baseLoad;
    logic [IDX_W-1:0] baseVal;
    logic             rotLoad;
    logic             rotVal;
  } strobe_t;

  // rank of the most urgent set bit counted from base; LINES when empty
  function automatic logic [IDX_W:0] prioIdx(logic [LINES-1:0] vec, logic [IDX_W-1:0] base);
    logic [IDX_W:0]   res;
    logic [IDX_W-1:0] pos;
    res = (IDX_W+1)'(LINES);
    for (int n = LINES - 1; n >= 0; n--) begin
      pos = base + IDX_W'(n);
      if (vec[pos]) res = (IDX_W+1)'(n);
    end
    return res;
  endfunction
endpackage

// File: rtl/rpr_resolve.sv
module rpr_resolve
  import rpr_pkg::*;
(
  input  logic [LINES-1:0] cand,
  input  logic [LINES-1:0] isrEff,
  input  logic [IDX_W-1:0] base,
  output logic             hit,
  output logic [IDX_W-1:0] line
);
  logic [IDX_W:0] candIdx;
  logic [IDX_W:0] isrIdx;

  always_comb begin
    candIdx = prioIdx(cand, base);
    isrIdx  = prioIdx(isrEff, base);
    hit     = candIdx < isrIdx;
    line    = base + candIdx[IDX_W-1:0];
  end
endmodule

// File: rtl/rpr_ctrl.sv
module rpr_ctrl
  import rpr_pkg::*;
(
  input  logic             ackStrobe,
  input  logic             autoEoi,
  input  logic             cmdStrobe,
  input  logic [2:0]       cmdCode,
  input  logic [IDX_W-1:0] cmdLevel,
  input  logic [LINES-1:0] isrQ,
  input  logic [IDX_W-1:0] baseQ,
  input  logic             rotQ,
  input  logic             curReq,
  input  logic [IDX_W-1:0] curLine,
  output strobe_t          st
);
  logic [IDX_W:0]   topIdx;
  logic             topHit;
  logic [IDX_W-1:0] topLine;

  always_comb begin
    topIdx  = prioIdx(isrQ, baseQ);
    topHit  = topIdx < (IDX_W+1)'(LINES);
    topLine = baseQ + topIdx[IDX_W-1:0];
  end

  always_comb begin
    st          = '0;
    st.ackGo    = ackStrobe & curReq;
    st.ackLine  = curLine;
    st.setIsr   = st.ackGo & ~autoEoi;
    if (st.ackGo && autoEoi && rotQ) begin
      st.baseLoad = 1'b1;
      st.baseVal  = curLine + 1'b1;
    end
    if (cmdStrobe) begin
      case (cmd_e'(cmdCode))
        CMD_ROT_OFF, CMD_ROT_ON: begin
          st.rotLoad = 1'b1;
          st.rotVal  = cmdCode[2];
        end
        CMD_EOI_TOP, CMD_EOI_TOP_R: begin
          if (topHit) begin
            st.isrClr[topLine] = 1'b1;
            if (cmdCode[2]) begin
              st.baseLoad = 1'b1;
              st.baseVal  = topLine + 1'b1;
            end
          end
        end
        CMD_EOI_AT, CMD_EOI_AT_R: begin
          st.isrClr[cmdLevel] = 1'b1;
          if (cmdCode[2]) begin
            st.baseLoad = 1'b1;
            st.baseVal  = cmdLevel + 1'b1;
          end
        end
        CMD_SET_BASE: begin
          st.baseLoad = 1'b1;
          st.baseVal  = cmdLevel + 1'b1;
        end
        CMD_NOP: ;
      endcase
    end
  end
endmodule

// File: rtl/rpr_datapath.sv
module rpr_datapath
  import rpr_pkg::*;
#(
  parameter logic [LINES-1:0] LEVEL_OK  = 8'hF8,
  parameter bit               IS_MASTER = 1'b1,
  parameter int               NEST_LINE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] reqLines,
  input  logic [LINES-1:0] levelSel,
  input  logic [LINES-1:0] maskBits,
  input  logic             fullyNested,
  input  strobe_t          st,
  output logic [LINES-1:0] isrQ,
  output logic [IDX_W-1:0] baseQ,
  output logic             rotQ,
  output logic             curReq,
  output logic [IDX_W-1:0] curLine,
  output logic             intReq,
  output logic [IDX_W-1:0] intLevel
);
  logic [LINES-1:0] irrQ, lastQ;
  logic [LINES-1:0] irrNext, isrNext;
  logic [LINES-1:0] effLevel, rise, ackVec, nestDrop;
  logic [IDX_W-1:0] baseNext;
  logic             rotNext;
  logic             nextHit;
  logic [IDX_W-1:0] nextLine;

  assign effLevel = levelSel & LEVEL_OK;
  assign rise     = reqLines & ~lastQ;
  assign ackVec   = st.ackGo ? (LINES'(1) << st.ackLine) : '0;

  generate
    if (IS_MASTER) begin : g_nest
      assign nestDrop = fullyNested ? (LINES'(1) << NEST_LINE) : '0;
    end else begin : g_flat
      assign nestDrop = '0;
    end
  endgenerate

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      assign irrNext[i] = effLevel[i] ? reqLines[i]
                                      : ((irrQ[i] & ~ackVec[i]) | rise[i]);
    end
  endgenerate

  assign isrNext  = (isrQ | (st.setIsr ? ackVec : '0)) & ~st.isrClr;
  assign baseNext = st.baseLoad ? st.baseVal : baseQ;
  assign rotNext  = st.rotLoad ? st.rotVal : rotQ;

  rpr_resolve u_cur (
    .cand   (irrQ & ~maskBits),
    .isrEff (isrQ & ~nestDrop),
    .base   (baseQ),
    .hit    (curReq),
    .line   (curLine)
  );

  rpr_resolve u_next (
    .cand   (irrNext & ~maskBits),
    .isrEff (isrNext & ~nestDrop),
    .base   (baseNext),
    .hit    (nextHit),
    .line   (nextLine)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irrQ     <= '0;
      lastQ    <= '0;
      isrQ     <= '0;
      baseQ    <= '0;
      rotQ     <= 1'b0;
      intReq   <= 1'b0;
      intLevel <= '0;
    end else begin
      irrQ     <= irrNext;
      lastQ    <= reqLines;
      isrQ     <= isrNext;
      baseQ    <= baseNext;
      rotQ     <= rotNext;
      intReq   <= nextHit;
      intLevel <= nextHit ? nextLine : '0;
    end
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter logic [LINES-1:0] LEVEL_OK  = 8'hF8,
  parameter bit               IS_MASTER = 1'b1,
  parameter int               NEST_LINE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] reqLines,
  input  logic [LINES-1:0] levelSel,
  input  logic [LINES-1:0] maskBits,
  input  logic             fullyNested,
  input  logic             autoEoi,
  input  logic             ackStrobe,
  input  logic             cmdStrobe,
  input  logic [2:0]       cmdCode,
  input  logic [IDX_W-1:0] cmdLevel,
  output logic             intReq,
  output logic [IDX_W-1:0] intLevel
);
  strobe_t          st;
  logic [LINES-1:0] isrQ;
  logic [IDX_W-1:0] baseQ;
  logic             rotQ;
  logic             curReq;
  logic [IDX_W-1:0] curLine;

  rpr_ctrl u_ctrl (
    .ackStrobe (ackStrobe),
    .autoEoi   (autoEoi),
    .cmdStrobe (cmdStrobe),
    .cmdCode   (cmdCode),
    .cmdLevel  (cmdLevel),
    .isrQ      (isrQ),
    .baseQ     (baseQ),
    .rotQ      (rotQ),
    .curReq    (curReq),
    .curLine   (curLine),
    .st        (st)
  );

  rpr_datapath #(
    .LEVEL_OK  (LEVEL_OK),
    .IS_MASTER (IS_MASTER),
    .NEST_LINE (NEST_LINE)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqLines    (reqLines),
    .levelSel    (levelSel),
    .maskBits    (maskBits),
    .fullyNested (fullyNested),
    .st          (st),
    .isrQ        (isrQ),
    .baseQ       (baseQ),
    .rotQ        (rotQ),
    .curReq      (curReq),
    .curLine     (curLine),
    .intReq      (intReq),
    .intLevel    (intLevel)
  );
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker
  import rpr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] maskBits,
  input logic             ackStrobe,
  input logic             autoEoi,
  input logic             cmdStrobe,
  input logic [2:0]       cmdCode,
  input logic [IDX_W-1:0] cmdLevel,
  input logic             intReq,
  input logic [LINES-1:0] isrQ,
  input logic [IDX_W-1:0] baseQ,
  input logic             curReq,
  input logic [IDX_W-1:0] curLine
);
  // R1: the cycle after a reset cycle is quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!intReq && isrQ == '0 && baseQ == '0));

  // R5: everything masked at the edge gives no request
  p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(maskBits)) |-> !intReq);

  // R7: an acknowledge outside automatic mode takes the line into service
  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ackStrobe && curReq && !autoEoi && !cmdStrobe) |=> isrQ[$past(curLine)]);

  // R9: a specific end of interrupt leaves the line out of service
  p_specific_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStrobe && (cmdCode == 3'd3 || cmdCode == 3'd7)) |=> !isrQ[$past(cmdLevel)]);

  // R10: set-base command loads level + 1
  p_set_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStrobe && cmdCode == 3'd6) |=> baseQ == IDX_W'($past(cmdLevel) + 1'b1));

  // R10: the no-op command alone leaves service and base untouched
  p_nop_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStrobe && cmdCode == 3'd2 && !ackStrobe) |=> ($stable(isrQ) && $stable(baseQ)));
endmodule

bind rot_prio_resolver rpr_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .maskBits  (maskBits),
  .ackStrobe (ackStrobe),
  .autoEoi   (autoEoi),
  .cmdStrobe (cmdStrobe),
  .cmdCode   (cmdCode),
  .cmdLevel  (cmdLevel),
  .intReq    (intReq),
  .isrQ      (isrQ),
  .baseQ     (baseQ),
  .curReq    (curReq),
  .curLine   (curLine)
);

// File: tb/rot_prio_resolver_tb_top.sv
`timescale 1ns/1ps
module rot_prio_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reqLines = '0, levelSel = '0, maskBits = '0;
  logic       fullyNested = 1'b0, autoEoi = 1'b0, ackStrobe = 1'b0, cmdStrobe = 1'b0;
  logic [2:0] cmdCode = '0, cmdLevel = '0;
  logic       intReq;
  logic [2:0] intLevel;

  always #2.5 clk = ~clk;

  rot_prio_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .reqLines(reqLines), .levelSel(levelSel),
    .maskBits(maskBits), .fullyNested(fullyNested), .autoEoi(autoEoi),
    .ackStrobe(ackStrobe), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode),
    .cmdLevel(cmdLevel), .intReq(intReq), .intLevel(intLevel)
  );

  int    checks = 0, fails = 0, cycles = 0;
  bit    started = 0, done = 0;
  string tag = "R1";

  // behavioural reference state
  bit [7:0] mIrr, mIsr, mLast;
  int       mBase;
  bit       mRot, mReq;
  int       mLine;

  function automatic int rankOf(bit [7:0] v, int b);
    for (int n = 0; n < 8; n++) if (v[(n + b) % 8]) return n;
    return 8;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      mIrr = 0; mIsr = 0; mLast = 0; mBase = 0; mRot = 0; mReq = 0; mLine = 0;
    end else begin
      bit [7:0] nIrr, nIsr, ie, lvl;
      int nBase, ci, ii, ln, k;
      bit go, nRot;
      ie = mIsr; if (fullyNested) ie[2] = 1'b0;
      ci = rankOf(mIrr & ~maskBits, mBase);
      ii = rankOf(ie, mBase);
      go = ackStrobe && (ci < ii);
      ln = (ci + mBase) % 8;
      lvl = levelSel & 8'hF8;
      for (int i = 0; i < 8; i++) begin
        if (lvl[i]) nIrr[i] = reqLines[i];
        else begin
          nIrr[i] = mIrr[i];
          if (go && ln == i) nIrr[i] = 1'b0;
          if (reqLines[i] && !mLast[i]) nIrr[i] = 1'b1;
        end
      end
      nIsr = mIsr; nBase = mBase; nRot = mRot;
      if (go) begin
        if (!autoEoi) nIsr[ln] = 1'b1;
        else if (mRot) nBase = (ln + 1) % 8;
      end
      if (cmdStrobe) begin
        case (cmdCode)
          3'd0, 3'd4: nRot = cmdCode[2];
          3'd1, 3'd5: begin
            k = rankOf(mIsr, mBase);
            if (k < 8) begin
              nIsr[(k + mBase) % 8] = 1'b0;
              if (cmdCode == 3'd5) nBase = (k + mBase + 1) % 8;
            end
          end
          3'd3, 3'd7: begin
            nIsr[cmdLevel] = 1'b0;
            if (cmdCode == 3'd7) nBase = (cmdLevel + 1) % 8;
          end
          3'd6: nBase = (cmdLevel + 1) % 8;
          default: ;
        endcase
      end
      mIrr = nIrr; mIsr = nIsr; mBase = nBase; mRot = nRot; mLast = reqLines;
      ie = mIsr; if (fullyNested) ie[2] = 1'b0;
      ci = rankOf(mIrr & ~maskBits, mBase);
      ii = rankOf(ie, mBase);
      mReq = ci < ii;
      mLine = mReq ? (ci + mBase) % 8 : 0;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (intReq !== mReq || int'(intLevel) != mLine || $isunknown(intLevel)) begin
        fails++;
        $display("FAIL %s cycle %0d: intReq/intLevel got %0b/%0d expected %0b/%0d",
                 tag, cycles, intReq, intLevel, mReq, mLine);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic ack();
    ackStrobe = 1'b1; tick(); ackStrobe = 1'b0;
  endtask

  task automatic cmd(bit [2:0] code, bit [2:0] lv);
    cmdStrobe = 1'b1; cmdCode = code; cmdLevel = lv; tick(); cmdStrobe = 1'b0;
  endtask

  initial begin
    bit [15:0] lfsr;
    lfsr = 16'hACE1;
    tag = "R1"; tick(4); rst_n = 1'b1; tick(2);

    tag = "R2"; reqLines[0] = 1; tick(); reqLines[0] = 0; tick(3);
    reqLines[1] = 1; tick(4);
    tag = "R4"; reqLines[4] = 1; reqLines[6] = 1; tick(3);
    tag = "R7"; ack(); tick(2);
    tag = "R8"; cmd(3'd1, 3'd0); tick(2); ack(); tick(); cmd(3'd5, 3'd0); tick(2);
    cmd(3'd1, 3'd0); tick();
    tag = "R9"; ack(); tick(); cmd(3'd7, 3'd4); tick(2); ack(); tick(); cmd(3'd3, 3'd6); tick(2);
    tag = "R10"; cmd(3'd6, 3'd7); tick(); cmd(3'd2, 3'd3); tick(2);
    reqLines = 8'h00; tick(2);
    reqLines[3] = 1; tick(); ack(); cmd(3'd2, 3'd0); tick(); cmd(3'd3, 3'd3); tick();

    tag = "R3"; levelSel[5] = 1; reqLines[5] = 1; tick(3); reqLines[5] = 0; tick(2);
    reqLines[5] = 1; tick(); ack(); tick(2); cmd(3'd3, 3'd5); tick(); reqLines[5] = 0; tick(2);
    levelSel[1] = 1; reqLines[1] = 0; tick(); reqLines[1] = 1; tick(2); ack(); tick(2);
    cmd(3'd1, 3'd0); tick();

    tag = "R5"; maskBits = 8'hFF; reqLines = 8'hFF; tick(3); maskBits = 8'hF0; tick(2);
    maskBits = 8'h0F; tick(2); maskBits = 8'h00; reqLines = 8'h00; tick(2);
    for (int i = 0; i < 8; i++) cmd(3'd3, 3'(i));
    tick(2);

    tag = "R6"; levelSel = '0; fullyNested = 1; reqLines[2] = 1; tick(2); ack(); tick();
    reqLines[2] = 0; tick(); reqLines[2] = 1; tick(2); ack(); tick();
    reqLines[2] = 0; tick(); reqLines[2] = 1; tick(); fullyNested = 0; tick(2);
    fullyNested = 1; tick(); cmd(3'd3, 3'd2); tick(); fullyNested = 0; reqLines[2] = 0;
    cmd(3'd3, 3'd2); tick(2);

    tag = "R11"; cmd(3'd4, 3'd0); autoEoi = 1; reqLines[3] = 1; reqLines[0] = 1; tick(2);
    ack(); tick(); ack(); tick(); reqLines = 0; tick();
    cmd(3'd0, 3'd0); reqLines[6] = 1; reqLines[1] = 1; tick(); ack(); tick(); ack(); tick(2);
    autoEoi = 0; reqLines = 0; tick(2);

    tag = "R12";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); cycles++;
      for (int s = 0; s < 16; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reqLines    = lfsr[7:0] ^ {lfsr[3:0], lfsr[15:12]};
      if (lfsr[9:8] == 2'b00) levelSel = lfsr[15:8];
      maskBits    = (lfsr[12:10] == 3'd0) ? lfsr[7:0] : 8'h00;
      ackStrobe   = lfsr[1:0] == 2'b11;
      cmdStrobe   = lfsr[6:4] == 3'b101;
      cmdCode     = lfsr[11:9];
      cmdLevel    = lfsr[14:12];
      if (lfsr[7:2] == 6'h15) fullyNested = ~fullyNested;
      if (lfsr[7:2] == 6'h2A) autoEoi = ~autoEoi;
      if (c == 2500) begin tag = "R1"; rst_n = 1'b0; end
      if (c == 2503) begin tag = "R12"; rst_n = 1'b1; end
    end
    ackStrobe = 0; cmdStrobe = 0; tick(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule